// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block is the timekeeping core of a real-time clock. It holds seconds, minutes, hours, day of week, day of month, month and a two-digit year as packed BCD bytes and advances them once per second. A fast enable input `tick_in` is divided by a sub-second phase counter. Every `TICKS_PER_SEC`-th qualifying pulse is one second. The carry ripples through minutes, hours, weekday, date, month and year. Month lengths and leap years follow the Gregorian rule for 2000 to 2099.

The hour byte selects its own format. With bit 6 clear the byte is a 24-hour BCD value. With bit 6 set, bits 4:0 hold a BCD hour from 1 to 12 and bit 5 flags PM. The carry logic keeps this encoding correct through noon and midnight.

A bus writes each field directly. A control byte at address 7 stops the oscillator. Reads come from a capture copy that follows the live registers one cycle behind. A host can freeze that copy for the length of a multi-byte read, so all the bytes it fetches belong to the same second.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the fields read sec 0x00, min 0x00, hour 0x00 (24-hour), weekday 0x01, date 0x01, month 0x01, year 0x00, and control (address 7) reads 0x80, so counting is stopped.
- R2: Address 0 (seconds) and address 1 (minutes) count BCD 0x00..0x59. Seconds wrap from 0x59 to 0x00 and advance the minutes. Minutes wrap from 0x59 to 0x00 and advance the hour.
- R3: With hour bit 6 clear (24-hour mode), address 2 counts 0x00..0x23. Wrapping from 0x23 to 0x00 advances the day.
- R4: With hour bit 6 set (12-hour mode), bits 4:0 count BCD 12, 1, ..., 11, and bit 5 is PM. Stepping 11 to 12 toggles PM. Stepping 12 to 1 keeps PM. Stepping 11 PM (0x71) to 12 AM (0x52) advances the day.
- R5: Address 3 (weekday) counts 0x01..0x07 and returns to 0x01 on the day carry after 0x07.
- R6: Address 4 (date) wraps to 0x01 and advances address 5 (month) after the month's last day. April, June, September and November have 30 days. February has 29 days when the year is divisible by 4 and 28 otherwise. All other months have 31. Month 0x12 wraps to 0x01 and advances address 6 (year). Year 0x99 wraps to 0x00.
- R7: Control bit 7 at address 7 is an active-low oscillator enable. While it is 1, no field changes except by a bus write, and the sub-second phase holds.
- R8: One second is exactly `TICKS_PER_SEC` counted `tick_in` pulses. A write to seconds clears the phase, so the next advance comes after a full `TICKS_PER_SEC` further pulses.
- R9: A write to address 0..6 loads the byte unchanged into that field. During any write cycle, `tick_in` is not counted.
- R10: `rd_data` returns byte `rd_addr` of a capture copy. The copy reloads from the live registers on every clock while `rd_freeze` is low, and holds unchanged while `rd_freeze` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Sub-second enable pulse |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address (0..6 time fields, 7 control) |
| wr_data | input | 8 | Write byte |
| rd_freeze | input | 1 | Hold the capture copy during a burst read |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Byte from the capture copy |

## Verification
A wrong carry or a bad month-length decision does not show at once. It surfaces at the ports only on the second that crosses that boundary, and from then on it stays in every later value. The bench therefore drives the clock across each boundary of interest: end of minute, end of day, noon and midnight in 12-hour mode, 30-day months, February with and without a leap year, and the end of the century. A per-cycle reference model catches any divergence one clock after the capture copy reloads. A phase error moves every later second by whole ticks, and shows up on the first read after the edge where the second should have advanced.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] wday;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } cal_time_t;

  localparam cal_time_t CAL_RESET = '{year: 8'h00, mon: 8'h01, date: 8'h01,
                                      wday: 8'h01, hour: 8'h00, min: 8'h00,
                                      sec: 8'h00};
  localparam logic [7:0] CTRL_RESET = 8'h80;
  localparam logic [2:0] CTRL_ADDR  = 3'd7;

  // one BCD step, low digit 9 rolls into the tens digit
  function automatic logic [7:0] bcd_next(input logic [7:0] b);
    if (b[3:0] == 4'h9) return {b[7:4] + 4'd1, 4'h0};
    else                return {b[7:4], b[3:0] + 4'd1};
  endfunction

  // divisible by four, judged on the two BCD digits
  function automatic logic leap_year(input logic [7:0] y);
    if (y[4] == 1'b0) return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
    else              return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
  endfunction

  function automatic logic [7:0] days_in_month(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // returns {day_carry, next_hour_byte}; format bits are preserved
  function automatic logic [8:0] hour_next(input logic [7:0] h);
    logic [7:0] inc;
    if (h[6]) begin
      inc = bcd_next({3'b000, h[4:0]});
      if (h[4:0] == 5'h12)      return {1'b0, h[7:5], 5'h01};
      else if (h[4:0] == 5'h11) return {h[5], h[7:6], ~h[5], 5'h12};
      else                      return {1'b0, h[7:5], inc[4:0]};
    end else begin
      inc = bcd_next({2'b00, h[5:0]});
      if (h[5:0] == 6'h23) return {1'b1, h[7:6], 6'h00};
      else                 return {1'b0, h[7:6], inc[5:0]};
    end
  endfunction

endpackage

// File: rtl/cal_subsec.sv
module cal_subsec #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic run,
  input  logic hold,
  input  logic clear,
  output logic sec_evt
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          count_en;

  assign count_en = tick_in && run && !hold;
  assign sec_evt  = count_en && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear)    cnt_q <= '0;
    else if (sec_evt)  cnt_q <= '0;
    else if (count_en) cnt_q <= cnt_q + 1'b1;
  end

  // R8: two seconds never come on adjacent clocks
  assert_evt_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |=> !sec_evt);

  // R7: a stopped oscillator leaves the phase untouched
  assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/cal_counter.sv
module cal_counter
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_evt,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output cal_time_t  now
);
  cal_time_t  t_q;
  logic [8:0] hr_nx;
  logic       min_step, hr_step, day_step, mon_step, yr_step;
  logic [7:0] month_end;

  assign hr_nx     = hour_next(t_q.hour);
  assign month_end = days_in_month(t_q.mon, t_q.year);

  // carry chain, each stage named for the checks below
  assign min_step = sec_evt && !wr_en && (t_q.sec == 8'h59);
  assign hr_step  = min_step && (t_q.min == 8'h59);
  assign day_step = hr_step && hr_nx[8];
  assign mon_step = day_step && (t_q.date == month_end);
  assign yr_step  = mon_step && (t_q.mon == 8'h12);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= CAL_RESET;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: t_q.sec  <= wr_data;
        3'd1: t_q.min  <= wr_data;
        3'd2: t_q.hour <= wr_data;
        3'd3: t_q.wday <= wr_data;
        3'd4: t_q.date <= wr_data;
        3'd5: t_q.mon  <= wr_data;
        3'd6: t_q.year <= wr_data;
        default: ;
      endcase
    end else if (sec_evt) begin
      t_q.sec <= min_step ? 8'h00 : bcd_next(t_q.sec);
      if (min_step) t_q.min  <= hr_step ? 8'h00 : bcd_next(t_q.min);
      if (hr_step)  t_q.hour <= hr_nx[7:0];
      if (day_step) begin
        t_q.wday <= (t_q.wday == 8'h07) ? 8'h01 : bcd_next(t_q.wday);
        t_q.date <= mon_step ? 8'h01 : bcd_next(t_q.date);
      end
      if (mon_step) t_q.mon  <= yr_step ? 8'h01 : bcd_next(t_q.mon);
      if (yr_step)  t_q.year <= (t_q.year == 8'h99) ? 8'h00 : bcd_next(t_q.year);
    end
  end

  assign now = t_q;

  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    min_step |=> (t_q.sec == 8'h00));

  assert_min_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hr_step |=> (t_q.min == 8'h00));

  assert_midnight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_step && !t_q.hour[6] && t_q.hour[5:0] == 6'h23) |=> (t_q.hour[5:0] == 6'h00));

  assert_noon_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_step && t_q.hour[6] && t_q.hour[4:0] == 5'h11) |=> (t_q.hour[5] != $past(t_q.hour[5])));

  assert_day_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && t_q.wday == 8'h07) |=> (t_q.wday == 8'h01));

  assert_year_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_step && t_q.mon == 8'h12) |=> (t_q.mon == 8'h01 && t_q.year != $past(t_q.year)));

  assert_write_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> (t_q.sec == $past(wr_data)));

endmodule

// File: rtl/cal_capture.sv
module cal_capture
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       freeze,
  input  cal_time_t  live,
  input  logic [7:0] ctrl,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data
);
  logic [7:0][7:0] shad_q;
  logic [7:0][7:0] live_v;

  assign live_v = {ctrl, live};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       shad_q <= {CTRL_RESET, CAL_RESET};
    else if (!freeze) shad_q <= live_v;
  end

  assign rd_data = shad_q[rd_addr];

  assert_freeze_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(shad_q));

  assert_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze |=> (shad_q == $past(live_v)));

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_in,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_freeze,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data
);
  logic       halt_q;
  logic       sec_evt;
  logic       wr_sec;
  cal_time_t  live_time;

  assign wr_sec = wr_en && (wr_addr == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              halt_q <= CTRL_RESET[7];
    else if (wr_en && wr_addr == CTRL_ADDR)  halt_q <= wr_data[7];
  end

  cal_subsec #(.DIV(TICKS_PER_SEC)) u_subsec (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_in (tick_in),
    .run     (!halt_q),
    .hold    (wr_en),
    .clear   (wr_sec),
    .sec_evt (sec_evt)
  );

  cal_counter u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .sec_evt (sec_evt),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .now     (live_time)
  );

  cal_capture u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .freeze  (rd_freeze),
    .live    (live_time),
    .ctrl    ({halt_q, 7'b0}),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !wr_en) |=> $stable(live_time));

endmodule

// File: tb/bcd_calendar_clock_bench.sv
module bcd_calendar_clock_bench;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_in = 1'b0, wr_en = 1'b0, rd_freeze = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  bcd_calendar_clock #(.TICKS_PER_SEC(DIV)) u_bcd_calendar_clock (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_freeze(rd_freeze),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // ---- behavioural reference: binary integers, converted on read ----
  int m_sec, m_min, m_hr, m_wd, m_date, m_mon, m_yr, m_ph;
  bit m_12, m_halt;
  logic [7:0] m_shadow [8];

  function automatic logic [7:0] to_bcd(int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int from_bcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int month_days(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] model_byte(int i);
    int h12;
    case (i)
      0: return to_bcd(m_sec);
      1: return to_bcd(m_min);
      2: begin
        if (!m_12) return to_bcd(m_hr);
        h12 = (m_hr % 12 == 0) ? 12 : m_hr % 12;
        return 8'h40 | (m_hr >= 12 ? 8'h20 : 8'h00) | to_bcd(h12);
      end
      3: return to_bcd(m_wd);
      4: return to_bcd(m_date);
      5: return to_bcd(m_mon);
      6: return to_bcd(m_yr);
      default: return m_halt ? 8'h80 : 8'h00;
    endcase
  endfunction

  task automatic model_second();
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0;
    m_wd = (m_wd == 7) ? 1 : m_wd + 1;
    m_date++;
    if (m_date <= month_days(m_mon, m_yr)) return;
    m_date = 1; m_mon++;
    if (m_mon <= 12) return;
    m_mon = 1; m_yr = (m_yr + 1) % 100;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_12 = 0; m_wd = 1; m_date = 1;
      m_mon = 1; m_yr = 0; m_halt = 1; m_ph = 0;
      for (int i = 0; i < 8; i++) m_shadow[i] = model_byte(i);
    end else begin
      if (!rd_freeze) for (int i = 0; i < 8; i++) m_shadow[i] = model_byte(i);
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_sec = from_bcd(wr_data); m_ph = 0; end
          3'd1: m_min = from_bcd(wr_data);
          3'd2: begin
            m_12 = wr_data[6];
            if (wr_data[6]) m_hr = (from_bcd({3'b0, wr_data[4:0]}) % 12) + (wr_data[5] ? 12 : 0);
            else            m_hr = from_bcd({2'b0, wr_data[5:0]});
          end
          3'd3: m_wd = from_bcd(wr_data);
          3'd4: m_date = from_bcd(wr_data);
          3'd5: m_mon = from_bcd(wr_data);
          3'd6: m_yr = from_bcd(wr_data);
          default: m_halt = wr_data[7];
        endcase
      end else if (tick_in && !m_halt) begin
        if (m_ph == DIV - 1) begin m_ph = 0; model_second(); end
        else m_ph++;
      end
    end
  end

  // ---- stimulus helpers ----
  task automatic cyc(input bit t, input bit w, input logic [2:0] a,
                     input logic [7:0] d, input bit f);
    tick_in = t; wr_en = w; wr_addr = a; wr_data = d; rd_freeze = f;
    rd_addr = rd_addr + 3'd1;
    @(posedge clk); #1;
    total++;
    if (rd_data !== m_shadow[rd_addr]) begin
      bad++;
      $display("FAIL R10 model compare addr=%0d actual=%h expected=%h",
               rd_addr, rd_data, m_shadow[rd_addr]);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b0, 1'b1, a, d, 1'b0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 3'd0, 8'h00, 1'b0);
  endtask

  task automatic settle();
    cyc(1'b0, 1'b0, 3'd0, 8'h00, rd_freeze);
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    rd_addr = a; #1;
    total++;
    if (rd_data !== exp) begin
      bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rd_data, exp);
    end
  endtask

  task automatic end_of_day(input logic [7:0] hour);
    wr(3'd2, hour); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 3'd0, 8'h00, 1'b0);
    rst_n = 1'b1;
    settle();
    // R1 reset state
    expect_rd(3'd0, 8'h00, "R1 sec");   expect_rd(3'd1, 8'h00, "R1 min");
    expect_rd(3'd2, 8'h00, "R1 hour");  expect_rd(3'd3, 8'h01, "R1 wday");
    expect_rd(3'd4, 8'h01, "R1 date");  expect_rd(3'd5, 8'h01, "R1 mon");
    expect_rd(3'd6, 8'h00, "R1 year");  expect_rd(3'd7, 8'h80, "R1 ctrl");

    // R2 R3 R5 R6: non-leap Feb 28 23:59:58, weekday 7
    wr(3'd7, 8'h00);
    wr(3'd6, 8'h23); wr(3'd5, 8'h02); wr(3'd4, 8'h28); wr(3'd3, 8'h07);
    wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h58);
    run(7); settle();
    expect_rd(3'd0, 8'h59, "R8 one second after seven ticks");
    run(1); settle();
    expect_rd(3'd0, 8'h00, "R2 sec wrap");   expect_rd(3'd1, 8'h00, "R2 min wrap");
    expect_rd(3'd2, 8'h00, "R3 hour wrap");  expect_rd(3'd3, 8'h01, "R5 wday wrap");
    expect_rd(3'd4, 8'h01, "R6 date 28-day Feb"); expect_rd(3'd5, 8'h03, "R6 month step");

    // R6 leap February
    wr(3'd6, 8'h24); wr(3'd5, 8'h02); wr(3'd4, 8'h28); end_of_day(8'h23);
    run(4); settle();
    expect_rd(3'd4, 8'h29, "R6 leap Feb 29"); expect_rd(3'd5, 8'h02, "R6 leap month held");
    end_of_day(8'h23); run(4); settle();
    expect_rd(3'd4, 8'h01, "R6 leap date wrap"); expect_rd(3'd5, 8'h03, "R6 leap month step");

    // R6 thirty-day month and century wrap
    wr(3'd5, 8'h04); wr(3'd4, 8'h30); end_of_day(8'h23); run(4); settle();
    expect_rd(3'd4, 8'h01, "R6 April 30 wrap"); expect_rd(3'd5, 8'h05, "R6 April to May");
    wr(3'd6, 8'h99); wr(3'd5, 8'h12); wr(3'd4, 8'h31); end_of_day(8'h23); run(4); settle();
    expect_rd(3'd6, 8'h00, "R6 year 99 wrap"); expect_rd(3'd5, 8'h01, "R6 Dec to Jan");

    // R4 twelve-hour mode
    wr(3'd3, 8'h03); end_of_day(8'h71); run(4); settle();
    expect_rd(3'd2, 8'h52, "R4 11PM to 12AM"); expect_rd(3'd3, 8'h04, "R4 midnight day carry");
    end_of_day(8'h51); run(4); settle();
    expect_rd(3'd2, 8'h72, "R4 11AM to 12PM");
    wr(3'd1, 8'h59); wr(3'd0, 8'h59); run(4); settle();
    expect_rd(3'd2, 8'h61, "R4 12PM to 1PM");
    end_of_day(8'h52); run(4); settle();
    expect_rd(3'd2, 8'h41, "R4 12AM to 1AM"); expect_rd(3'd3, 8'h04, "R4 no carry at 1AM");

    // R7 oscillator stop
    wr(3'd7, 8'h80); run(20); settle();
    expect_rd(3'd7, 8'h80, "R7 ctrl readback");
    expect_rd(3'd0, 8'h00, "R7 sec held"); expect_rd(3'd1, 8'h00, "R7 min held");
    wr(3'd7, 8'h00);

    // R8 phase cleared by seconds write
    run(2); wr(3'd0, 8'h10); run(3); settle();
    expect_rd(3'd0, 8'h10, "R8 no advance before full second");
    run(1); settle();
    expect_rd(3'd0, 8'h11, "R8 advance after full second");

    // R9 write cycle does not count a tick, raw load
    run(3); cyc(1'b1, 1'b1, 3'd1, 8'h05, 1'b0); settle();
    expect_rd(3'd0, 8'h11, "R9 tick dropped on write");
    expect_rd(3'd1, 8'h05, "R9 minutes loaded");
    run(1); settle();
    expect_rd(3'd0, 8'h12, "R9 phase kept across write");

    // R10 freeze during burst
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, 3'd0, 8'h00, 1'b1);
    expect_rd(3'd0, 8'h12, "R10 frozen sec");
    expect_rd(3'd1, 8'h05, "R10 frozen min");
    settle();
    cyc(1'b0, 1'b0, 3'd0, 8'h00, 1'b0); settle();
    expect_rd(3'd0, 8'h14, "R10 copy refreshed");

    finish_up();
  end
endmodule